// File: doc/BRIEF.md
# Radio Reference Divider Chain

This block turns one 4 MHz reference clock into the fixed timing signals that a radio tuning loop and its controller need. Four counters are chained together. The first counter divides by 8 and gives a 500 kHz controller clock. Its one-cycle strobe then drives three further counters: a 25 kHz reference for the FM band, a 10 kHz reference for the AM band, and a 50 Hz time-of-day tick. Each tap is available in two forms: a one-cycle enable pulse and a 50% square wave. Both forms are in the input clock domain.

A band-select input picks which of the two references reaches the phase comparator. A new band is adopted only at the end of a full period of the reference in use. At that moment the counter of the incoming band restarts, so the comparator never receives a shortened period.

A power-down input holds both band counters at zero and keeps the reference outputs low. The controller clock and the time-of-day tick keep running without any change of phase, because they belong to the part of the chain that stays powered.

Top module: `radio_refdiv`

## Requirements
- R1: A synchronous active-high reset clears every counter. While reset is high and after it, all strobe and square outputs are low and `ref_band` reads 0 (AM).
- R2: `ctl_stb` pulses for one cycle on every 8th rising edge after reset release, first on edge 8. `ctl_sq` is low for 4 cycles and then high for 4 cycles, starting low.
- R3: With the FM band active (`ref_band` = 1), `ref_stb` pulses once every 160 cycles (25 kHz).
- R4: With the AM band active (`ref_band` = 0), `ref_stb` pulses once every 400 cycles (10 kHz). After reset the first pulse is on edge 401.
- R5: `tod_stb` pulses once every 80000 cycles (50 Hz), first on edge 80001. `tod_sq` is high for the second half of each such period.
- R6: While `pwr_dn` is high, `ref_stb` and `ref_sq` stay low. `ctl_stb`, `ctl_sq`, `tod_stb` and `tod_sq` continue unchanged, and the value of `band_fm` is copied to `ref_band` on each cycle.
- R7: When `pwr_dn` falls, the band counters restart from zero. The first reference pulse comes one full band period, counted in controller-clock strobes, after the first controller strobe that follows the release.
- R8: A change of `band_fm` (1 = FM, 0 = AM) is adopted in the cycle after the next `ref_stb` of the current band. The gap from that last old-band pulse to the first new-band pulse is exactly one full period of the new band.
- R9: If `band_fm` changes and returns to the active band before the active band's next pulse, the change has no effect: the pulse train and `ref_band` are unaltered.
- R10: Over any full period of the active band, `ref_sq` is high for exactly half the cycles: 80 of 160 for FM, 200 of 400 for AM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Holds the band reference counters idle |
| band_fm | input | 1 | Requested band: 1 = FM (25 kHz), 0 = AM (10 kHz) |
| ctl_stb | output | 1 | 500 kHz one-cycle enable |
| ctl_sq | output | 1 | 500 kHz square wave |
| tod_stb | output | 1 | 50 Hz one-cycle enable |
| tod_sq | output | 1 | 50 Hz square wave |
| ref_stb | output | 1 | Selected comparison reference, one-cycle enable |
| ref_sq | output | 1 | Selected comparison reference, square wave |
| ref_band | output | 1 | Band currently driving the reference outputs (1 = FM) |

## Verification
The hardest situation to reach is a band request that arrives mid-period. The stimulus must hold it until the boundary and then align the incoming counter, and it must also bounce a request and withdraw it before any boundary. Each is reached by driving `band_fm` on cycle numbers computed from the pulse schedule, so the request lands a known number of cycles before the old band's next pulse. Power-down is released on a cycle number chosen to fall just after a controller strobe, which gives an exact expected restart. The 50 Hz tick needs more than 160000 cycles to show two periods, so the run is planned so that the band and power-down cases finish early and the tick is checked on every cycle throughout.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;
endpackage

// File: rtl/refdiv_stage.sv
// One counter of the divider chain: it counts advance pulses modulo DIV.
module refdiv_stage #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic adv,
  output logic stb,
  output logic sq
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_V = CW'(HALF);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
      stb <= 1'b0;
    end else if (adv) begin
      if (cnt == LAST) begin
        cnt <= '0;
        stb <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
        stb <= 1'b0;
      end
    end else begin
      stb <= 1'b0;
    end
  end

  // square wave: low for the first half of the count, high for the second
  assign sq = (cnt >= HALF_V);

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb); // R2
  AST_STB_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb |-> (cnt == '0)); // R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0 && !stb)); // R7
endmodule

// File: rtl/refdiv_band_sel.sv
// Picks the comparison reference and defers band changes to a period boundary.
module refdiv_band_sel
  import refdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pwr_dn,
  input  logic  band_req,
  input  logic  fm_stb,
  input  logic  fm_sq,
  input  logic  am_stb,
  input  logic  am_sq,
  output logic  restart_fm,
  output logic  restart_am,
  output logic  ref_stb,
  output logic  ref_sq,
  output band_e band_act
);
  band_e req;
  logic  sel_stb;
  logic  change;

  assign req     = band_e'(band_req);
  assign sel_stb = (band_act == BAND_FM) ? fm_stb : am_stb;
  assign change  = sel_stb && (req != band_act) && !pwr_dn;

  // the incoming band's counter restarts on the switch edge
  assign restart_fm = change && (req == BAND_FM);
  assign restart_am = change && (req == BAND_AM);

  always_ff @(posedge clk) begin
    if (rst) begin
      band_act <= BAND_AM;
    end else if (pwr_dn || change) begin
      band_act <= req;
    end
  end

  assign ref_stb = sel_stb;
  assign ref_sq  = (band_act == BAND_FM) ? fm_sq : am_sq;

  AST_BAND_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_act) |-> ($past(pwr_dn) || $past(ref_stb))); // R8
endmodule

// File: rtl/radio_refdiv.sv
module radio_refdiv
  import refdiv_pkg::*;
#(
  parameter int CTL_DIV = 8,
  parameter int FM_DIV  = 20,
  parameter int AM_DIV  = 50,
  parameter int TOD_DIV = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_dn,
  input  logic band_fm,
  output logic ctl_stb,
  output logic ctl_sq,
  output logic tod_stb,
  output logic tod_sq,
  output logic ref_stb,
  output logic ref_sq,
  output logic ref_band
);
  logic  fm_stb, fm_sq, am_stb, am_sq;
  logic  restart_fm, restart_am;
  band_e band_act;

  // always-on part: controller clock and time-of-day tick
  refdiv_stage #(.DIV(CTL_DIV)) u_ctl (
    .clk(clk), .rst(rst), .hold(1'b0), .adv(1'b1),
    .stb(ctl_stb), .sq(ctl_sq)
  );

  refdiv_stage #(.DIV(TOD_DIV)) u_tod (
    .clk(clk), .rst(rst), .hold(1'b0), .adv(ctl_stb),
    .stb(tod_stb), .sq(tod_sq)
  );

  // switchable part: band references
  refdiv_stage #(.DIV(FM_DIV)) u_fm (
    .clk(clk), .rst(rst), .hold(pwr_dn | restart_fm), .adv(ctl_stb),
    .stb(fm_stb), .sq(fm_sq)
  );

  refdiv_stage #(.DIV(AM_DIV)) u_am (
    .clk(clk), .rst(rst), .hold(pwr_dn | restart_am), .adv(ctl_stb),
    .stb(am_stb), .sq(am_sq)
  );

  refdiv_band_sel u_sel (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .band_req(band_fm),
    .fm_stb(fm_stb), .fm_sq(fm_sq), .am_stb(am_stb), .am_sq(am_sq),
    .restart_fm(restart_fm), .restart_am(restart_am),
    .ref_stb(ref_stb), .ref_sq(ref_sq), .band_act(band_act)
  );

  assign ref_band = (band_act == BAND_FM);

  AST_REF_QUIET_PD: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!ref_stb && !ref_sq)); // R6
endmodule

// File: tb/radio_refdiv_bench.sv
module radio_refdiv_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic band_fm = 1'b0;
  logic ctl_stb, ctl_sq, tod_stb, tod_sq, ref_stb, ref_sq, ref_band;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tod_seen = 0;
  bit done = 1'b0;
  string cur_req = "R4";
  int exp_q[$];

  localparam int END_CYC = 165000;

  always #2 clk = ~clk;

  radio_refdiv u_radio_refdiv (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .band_fm(band_fm),
    .ctl_stb(ctl_stb), .ctl_sq(ctl_sq), .tod_stb(tod_stb), .tod_sq(tod_sq),
    .ref_stb(ref_stb), .ref_sq(ref_sq), .ref_band(ref_band)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n || rst) @(negedge clk);
  endtask

  task automatic push_pulses(input int first, input int step, input int last);
    for (int t = first; t <= last; t += step) exp_q.push_back(t);
  endtask

  task automatic count_high(input int from, input int to, output int hi);
    hi = 0;
    wait_cyc(from);
    for (int k = from; k <= to; k++) begin
      if (ref_sq) hi++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: fixed-rate taps every cycle, reference pulses against the scoreboard
  always @(negedge clk) begin
    if (!rst && cyc > 0 && !done) begin
      int e;
      chk(ctl_stb == (cyc % 8 == 0), "R2 ctl_stb", ctl_stb, cyc % 8 == 0);
      chk(ctl_sq == (cyc % 8 >= 4), "R2 ctl_sq", ctl_sq, cyc % 8 >= 4);
      chk(tod_stb == (cyc > 1 && cyc % 80000 == 1), "R5 tod_stb", tod_stb,
          cyc > 1 && cyc % 80000 == 1);
      chk(tod_sq == (((cyc - 1) / 8) % 10000 >= 5000), "R5 tod_sq", tod_sq,
          ((cyc - 1) / 8) % 10000 >= 5000);
      if (tod_stb) tod_seen++;
      if (ref_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected ref pulse"}, cyc, 0);
        end else begin
          e = exp_q.pop_front();
          chk(cyc == e, {cur_req, " ref pulse time"}, cyc, e);
        end
      end
    end
  end

  initial begin
    int hi;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({ctl_stb, ctl_sq, tod_stb, tod_sq, ref_stb, ref_sq} == 6'b0,
        "R1 outputs low in reset", {ctl_stb, ctl_sq, tod_stb, tod_sq, ref_stb, ref_sq}, 0);
    chk(ref_band == 1'b0, "R1 band after reset", ref_band, 0);
    push_pulses(401, 400, 1601);          // R4 AM after reset
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_sq == 1'b0 && ref_sq == 1'b0, "R1 outputs low after release", ctl_sq, 0);

    // R10: AM square over one full period
    count_high(802, 1201, hi);
    chk(hi == 200, "R10 AM square high count", hi, 200);

    // R8: request FM mid-period; adopted after the AM pulse at 1601
    wait_cyc(1300);
    band_fm = 1'b1;
    cur_req = "R8";
    push_pulses(1761, 160, 2401);
    wait_cyc(1601);
    chk(ref_band == 1'b0, "R8 band held until boundary", ref_band, 0);
    @(negedge clk);
    chk(ref_band == 1'b1, "R8 band adopted after boundary", ref_band, 1);

    // R3 / R10: FM period and square
    cur_req = "R3";
    count_high(1922, 2081, hi);
    chk(hi == 80, "R10 FM square high count", hi, 80);

    // R9: bounce the request and withdraw it before the next FM pulse
    wait_cyc(2100);
    cur_req = "R9";
    band_fm = 1'b0;
    wait_cyc(2120);
    band_fm = 1'b1;
    wait_cyc(2200);
    chk(ref_band == 1'b1, "R9 band unchanged by withdrawn request", ref_band, 1);

    // R6: power-down; ref quiet, band follows request directly
    wait_cyc(2450);
    cur_req = "R6";
    pwr_dn = 1'b1;
    wait_cyc(2700);
    band_fm = 1'b0;
    wait_cyc(2800);
    chk(ref_band == 1'b0, "R6 band follows request in power-down", ref_band, 0);
    hi = 0;
    for (int k = 2801; k <= 3000; k++) begin
      @(negedge clk);
      if (ref_sq || ref_stb) hi++;
    end
    chk(hi == 0, "R6 ref outputs low in power-down", hi, 0);

    // R7: release right after a controller strobe; AM restarts from zero
    wait_cyc(3000);
    pwr_dn = 1'b0;
    cur_req = "R7";
    push_pulses(3001 + 8 * 49, 400, END_CYC);

    wait_cyc(3800);
    cur_req = "R4";
    wait_cyc(END_CYC);
    chk(exp_q.size() == 0 || exp_q[0] > END_CYC, "R7 all due ref pulses seen",
        exp_q.size(), 0);
    chk(tod_seen == 2, "R5 tod pulse count", tod_seen, 2);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired cycle %0d expected %0d", cyc, END_CYC);
    finish_run();
  end
endmodule